// File: doc/BRIEF.md
# Packet Traffic Generator and Checker

This block drives a stream of fixed-size test packets onto a streaming transmit interface and inspects packets that come back on a streaming receive interface. It is typically used with a loopback path between the two. Each packet carries a 32-bit sequence number in its first word. Its channel tag and its payload words are computed from that number and from the word position, so the receive side can rebuild every expected word without storing anything that was sent.

Software uses a small word-addressed register port. Through it, software starts and stops generation, picks a packet size of 128, 256 or 512 bytes, and chooses between a batch of 100 packets and an endless run. It also reads four start/end-of-packet counters, sticky error flags and an error count, and uses two write-only command bits. One command bit clears the errors. The other clears a flag that reports that the transmit and receive counters agreed once traffic went quiet.

Top module: `pkt_traffic_engine`

Register addresses (reg_addr): 0 run (bit 0), 1 endless mode (bit 0), 2 packet size in bytes, 3 command (write only, reads 0), 4 sent SOPs, 5 sent EOPs, 6 received SOPs, 7 received EOPs, 8 error flags, 9 error count, 10 status (bit 0 counts-agree, bit 1 transmitter busy).

## Requirements
- R1: After reset, all counters, the error flags and the error count read 0. The run, mode and status registers read 0, the size register reads 128, and tx_valid is low.
- R2: Writing 1 to bit 0 of register 0 while the transmitter is idle raises tx_valid with a SOP beat on the second rising edge after the write edge. Writing 0 stops generation only at a packet boundary: the packet being offered is completed, so the sent SOP and EOP counts end up equal.
- R3: The size register accepts only a write of exactly 128, 256 or 512; any other value leaves it unchanged. A packet is size/(DATA_W/8) words long (16, 32 or 64 words at 64 bits), with tx_sop on word 0 and tx_eop on the last word. The length is latched when the packet is first offered.
- R4: With bit 0 of register 1 at 0, a run sends exactly 100 packets and then clears the run bit by itself.
- R5: With bit 0 of register 1 at 1, the run continues past 100 packets until software clears the run bit.
- R6: The first packet after reset has sequence number 0, and each later packet has the previous number plus 1. Word 0 is the sequence number repeated across the word. Word i (i ≥ 1) is {seq[15:0] XOR 16'hC3A5, i[15:0]} repeated across the word. tx_chan equals the low CHAN_W bits of seq on every beat.
- R7: While tx_valid is high and tx_ready is low, tx_valid, tx_data, tx_sop, tx_eop and tx_chan stay unchanged.
- R8: Registers 4 and 5 count transmit handshakes (tx_valid and tx_ready) that carry tx_sop and tx_eop respectively.
- R9: Registers 6 and 7 count received beats with rx_valid high that carry rx_sop and rx_eop respectively.
- R10: Error flags in register 8 are sticky. Bit 0 is set when a SOP word is not the expected next sequence pattern (order error). Bit 1 is set when rx_chan disagrees with the packet's received sequence number. Bit 2 is set when a payload word mismatches. Bit 3 is set when a SOP arrives inside a packet or a non-SOP beat arrives outside one. Register 9 counts beats with any error.
- R11: Writing 1 to bit 0 of register 3 clears the error flags and the error count and leaves the size, mode and run settings unchanged. An error arriving in the same cycle still sets its flag.
- R12: Status bit 0 is set once, after at least one packet has been sent, the generator is stopped, no packet is open on the receive side, and the sent and received SOP counts and EOP counts are pairwise equal. It clears when a new packet starts or when bit 1 of register 3 is written with 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| tx_valid | output | 1 | Transmit beat valid |
| tx_ready | input | 1 | Transmit sink ready |
| tx_data | output | DATA_W | Transmit data word |
| tx_sop | output | 1 | Transmit first word of packet |
| tx_eop | output | 1 | Transmit last word of packet |
| tx_chan | output | CHAN_W | Transmit channel tag |
| rx_valid | input | 1 | Receive beat valid |
| rx_data | input | DATA_W | Receive data word |
| rx_sop | input | 1 | Receive first word of packet |
| rx_eop | input | 1 | Receive last word of packet |
| rx_chan | input | CHAN_W | Receive channel tag |

## Verification
A wrong generator sequence or word index shows up on the very beat it is offered, because the bench rebuilds every expected word arithmetically and compares each handshake. A broken batch counter or stop rule shows up as a sent SOP count other than a multiple of 100, or as unequal SOP and EOP counts, as soon as the run settles. Checker state faults are exposed by injecting one fault per class and reading the flags a few cycles later. A misclassification then appears as a wrong bit, and a failure to resynchronise appears as extra errors on the following clean packet.

// File: rtl/pkt_traffic_engine.sv
module pkt_traffic_engine #(
  parameter int DATA_W     = 64,
  parameter int CHAN_W     = 4,
  parameter int CNT_W      = 32,
  parameter int BATCH_PKTS = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_sop,
  output logic              tx_eop,
  output logic [CHAN_W-1:0] tx_chan,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_sop,
  input  logic              rx_eop,
  input  logic [CHAN_W-1:0] rx_chan
);
  localparam int BPW       = DATA_W / 8;
  localparam int REP       = DATA_W / 32;
  localparam int MAX_WORDS = 512 / BPW;
  localparam int IDX_W     = $clog2(MAX_WORDS) + 1;
  localparam int BATCH_W   = $clog2(BATCH_PKTS + 1);
  localparam logic [15:0] PAY_MASK = 16'hC3A5;

  function automatic logic [DATA_W-1:0] head_word(input logic [31:0] s);
    return {REP{s}};
  endfunction

  function automatic logic [DATA_W-1:0] body_word(input logic [31:0] s, input logic [15:0] i);
    return {REP{s[15:0] ^ PAY_MASK, i}};
  endfunction

  // register decode
  wire wr_run  = reg_wr && reg_addr == 4'd0;
  wire wr_mode = reg_wr && reg_addr == 4'd1;
  wire wr_size = reg_wr && reg_addr == 4'd2;
  wire wr_cmd  = reg_wr && reg_addr == 4'd3;
  wire clr_err = wr_cmd && reg_wdata[0];
  wire clr_eq  = wr_cmd && reg_wdata[1];
  wire size_ok = reg_wdata == 32'd128 || reg_wdata == 32'd256 || reg_wdata == 32'd512;

  logic              run_en, run_d, cont_mode;
  logic [9:0]        size_bytes;
  logic [BATCH_W-1:0] batch, batch_d;

  // generator state
  logic              g_act;
  logic [IDX_W-1:0]  g_idx, g_len;
  logic [31:0]       g_seq;

  wire [IDX_W-1:0] cfg_words = IDX_W'(size_bytes / 10'(BPW));
  wire tx_fire = tx_valid && tx_ready;

  assign tx_valid = g_act;
  assign tx_sop   = g_act && g_idx == '0;
  assign tx_eop   = g_act && g_idx == g_len - 1'b1;
  assign tx_chan  = g_seq[CHAN_W-1:0];
  assign tx_data  = (g_idx == '0) ? head_word(g_seq) : body_word(g_seq, 16'(g_idx));

  always_comb begin
    run_d   = run_en;
    batch_d = batch;
    if (tx_fire && tx_eop) begin
      if (batch < BATCH_W'(BATCH_PKTS)) batch_d = batch + 1'b1;
      if (!cont_mode && batch >= BATCH_W'(BATCH_PKTS - 1)) run_d = 1'b0;
    end
    if (wr_run) begin
      run_d = reg_wdata[0];
      if (reg_wdata[0] && !run_en) batch_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_en     <= 1'b0;
      cont_mode  <= 1'b0;
      size_bytes <= 10'd128;
      batch      <= '0;
    end else begin
      run_en <= run_d;
      batch  <= batch_d;
      if (wr_mode) cont_mode <= reg_wdata[0];
      if (wr_size && size_ok) size_bytes <= reg_wdata[9:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      g_act <= 1'b0;
      g_idx <= '0;
      g_len <= '0;
      g_seq <= '0;
    end else if (!g_act) begin
      if (run_en) begin
        g_act <= 1'b1;
        g_idx <= '0;
        g_len <= cfg_words;
      end
    end else if (tx_fire) begin
      if (tx_eop) begin
        g_seq <= g_seq + 1'b1;
        g_idx <= '0;
        g_len <= cfg_words;
        g_act <= run_d;
      end else begin
        g_idx <= g_idx + 1'b1;
      end
    end
  end

  // checker
  logic        c_in;
  logic [31:0] c_exp, c_cur;
  logic [15:0] c_idx;
  wire  [31:0] rx_seq = rx_data[31:0];

  wire e_sop  = rx_valid && rx_sop && rx_data != head_word(c_exp);
  wire e_chan = rx_valid && (rx_sop ? rx_chan != rx_seq[CHAN_W-1:0]
                                    : c_in && rx_chan != c_cur[CHAN_W-1:0]);
  wire e_pay  = rx_valid && !rx_sop && c_in && rx_data != body_word(c_cur, c_idx);
  wire e_frm  = rx_valid && (rx_sop ? c_in : !c_in);
  wire [3:0] e_new = {e_frm, e_pay, e_chan, e_sop};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_in  <= 1'b0;
      c_exp <= '0;
      c_cur <= '0;
      c_idx <= '0;
    end else if (rx_valid) begin
      if (rx_sop) begin
        c_in  <= !rx_eop;
        c_cur <= rx_seq;
        c_exp <= rx_seq + 1'b1;
        c_idx <= 16'd1;
      end else if (c_in) begin
        c_idx <= c_idx + 1'b1;
        if (rx_eop) c_in <= 1'b0;
      end
    end
  end

  logic [3:0]       err_flags;
  logic [CNT_W-1:0] err_cnt;
  logic [CNT_W-1:0] tx_sop_cnt, tx_eop_cnt, rx_sop_cnt, rx_eop_cnt;
  logic             eq_arm, cnt_eq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_flags <= '0;
      err_cnt   <= '0;
    end else begin
      err_flags <= (clr_err ? 4'd0 : err_flags) | e_new;
      err_cnt   <= (clr_err ? '0 : err_cnt) + CNT_W'(|e_new);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sop_cnt <= '0;
      tx_eop_cnt <= '0;
      rx_sop_cnt <= '0;
      rx_eop_cnt <= '0;
    end else begin
      if (tx_fire && tx_sop)   tx_sop_cnt <= tx_sop_cnt + 1'b1;
      if (tx_fire && tx_eop)   tx_eop_cnt <= tx_eop_cnt + 1'b1;
      if (rx_valid && rx_sop)  rx_sop_cnt <= rx_sop_cnt + 1'b1;
      if (rx_valid && rx_eop)  rx_eop_cnt <= rx_eop_cnt + 1'b1;
    end
  end

  wire quiet = !run_en && !g_act && !c_in;
  wire match = tx_sop_cnt == rx_sop_cnt && tx_eop_cnt == rx_eop_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_eq) begin
      eq_arm <= 1'b0;
      cnt_eq <= 1'b0;
    end else if (tx_fire && tx_sop) begin
      eq_arm <= 1'b1;
      cnt_eq <= 1'b0;
    end else if (eq_arm && quiet && match) begin
      eq_arm <= 1'b0;
      cnt_eq <= 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      4'd0:    reg_rdata = {31'd0, run_en};
      4'd1:    reg_rdata = {31'd0, cont_mode};
      4'd2:    reg_rdata = {22'd0, size_bytes};
      4'd4:    reg_rdata = 32'(tx_sop_cnt);
      4'd5:    reg_rdata = 32'(tx_eop_cnt);
      4'd6:    reg_rdata = 32'(rx_sop_cnt);
      4'd7:    reg_rdata = 32'(rx_eop_cnt);
      4'd8:    reg_rdata = {28'd0, err_flags};
      4'd9:    reg_rdata = 32'(err_cnt);
      4'd10:   reg_rdata = {30'd0, g_act, cnt_eq};
      default: reg_rdata = 32'd0;
    endcase
  end

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_run && reg_wdata[0] && !tx_valid) |=> ##1 tx_valid);

  p_size_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    size_bytes == 10'd128 || size_bytes == 10'd256 || size_bytes == 10'd512);

  p_batch_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    batch <= BATCH_W'(BATCH_PKTS));

  p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data) && $stable(tx_sop)
                                && $stable(tx_eop) && $stable(tx_chan));

  p_tx_balance_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sop_cnt == tx_eop_cnt || tx_sop_cnt == tx_eop_cnt + 1'b1);

  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_err && !rx_valid) |=> err_flags == 4'd0 && err_cnt == '0);

  p_eq_match_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnt_eq) |-> tx_sop_cnt == rx_sop_cnt && tx_eop_cnt == rx_eop_cnt);
endmodule

// File: tb/pkt_traffic_engine_bench.sv
module pkt_traffic_engine_bench;
  localparam int DW = 64;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          reg_wr = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          tx_valid, tx_sop, tx_eop;
  logic          tx_ready = 1'b0;
  logic [DW-1:0] tx_data;
  logic [CW-1:0] tx_chan;
  logic          rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic [CW-1:0] rx_chan = '0;

  logic          inj = 1'b0;
  logic          i_valid = 1'b0, i_sop = 1'b0, i_eop = 1'b0;
  logic [DW-1:0] i_data = '0;
  logic [CW-1:0] i_chan = '0;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int rdy_mode = 0;
  bit done = 1'b0;

  pkt_traffic_engine u_pkt_traffic_engine (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_chan(tx_chan),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_chan(rx_chan)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // loopback or injection path, one register stage
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (inj) begin
      rx_valid <= i_valid; rx_data <= i_data; rx_sop <= i_sop; rx_eop <= i_eop; rx_chan <= i_chan;
    end else begin
      rx_valid <= tx_valid && tx_ready; rx_data <= tx_data;
      rx_sop <= tx_sop; rx_eop <= tx_eop; rx_chan <= tx_chan;
    end
    if (cyc == 190000 && !done) begin
      fails++;
      $display("FAIL watchdog R2: actual cycles %0d expected fewer than 190000", cyc);
      summary();
      $finish;
    end
  end

  // transmit monitor: ready pattern, stall stability, per-beat content
  logic [31:0]   m_seq = '0;
  int            m_idx = 0;
  int            m_words = 16;
  logic [DW-1:0] m_exp;
  logic          p_stall = 1'b0, p_sop = 1'b0, p_eop = 1'b0;
  logic [DW-1:0] p_data = '0;
  logic [CW-1:0] p_chan = '0;

  always @(negedge clk) begin
    case (rdy_mode)
      0:       tx_ready = 1'b1;
      1:       tx_ready = (cyc % 3) != 0;
      2:       tx_ready = (cyc % 5) < 2;
      default: tx_ready = 1'b0;
    endcase
    if (p_stall)
      chk(tx_valid && tx_data == p_data && tx_sop == p_sop && tx_eop == p_eop && tx_chan == p_chan,
          "R7 held beat", tx_data, p_data);
    if (tx_valid && tx_ready) begin
      m_exp = (m_idx == 0) ? {2{m_seq}} : {2{m_seq[15:0] ^ 16'hC3A5, 16'(m_idx)}};
      chk(tx_data == m_exp, "R6 data word", tx_data, m_exp);
      chk(tx_chan == m_seq[CW-1:0], "R6 channel", 64'(tx_chan), 64'(m_seq[CW-1:0]));
      chk(tx_sop == (m_idx == 0) && tx_eop == (m_idx == m_words - 1), "R3 sop/eop position",
          {tx_sop, tx_eop}, {(m_idx == 0), (m_idx == m_words - 1)});
      if (m_idx == m_words - 1) begin m_idx = 0; m_seq = m_seq + 1; end
      else m_idx = m_idx + 1;
    end
    p_stall = tx_valid && !tx_ready;
    p_data = tx_data; p_sop = tx_sop; p_eop = tx_eop; p_chan = tx_chan;
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] r0, st;
    forever begin
      rd(4'd0, r0); rd(4'd10, st);
      if (r0[0] == 1'b0 && st[1] == 1'b0) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] seq, input int bad_chan, input int bad_pay, input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      i_valid = 1'b1; i_sop = (i == 0); i_eop = (i == len - 1);
      i_data = (i == 0) ? {2{seq}} : {2{seq[15:0] ^ 16'hC3A5, 16'(i)}};
      if (i == bad_pay) i_data = i_data ^ 64'd1;
      i_chan = seq[CW-1:0];
      if (i == bad_chan) i_chan = i_chan ^ 4'd1;
    end
    @(negedge clk); i_valid = 1'b0; i_sop = 1'b0; i_eop = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, a, b;
    logic [31:0] n;
    repeat (3) @(negedge clk);
    chk(tx_valid == 1'b0, "R1 tx_valid in reset", 64'(tx_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_valid == 1'b0, "R1 tx_valid after reset", 64'(tx_valid), 0);
    for (int ad = 0; ad <= 10; ad++) begin
      rd(4'(ad), v);
      chk(v == ((ad == 2) ? 32'd128 : 32'd0), "R1 register reset value", v, (ad == 2) ? 128 : 0);
    end

    wr(4'd2, 32'd100);  rd(4'd2, v); chk(v == 32'd128, "R3 illegal size 100 ignored", v, 128);
    wr(4'd2, 32'd513);  rd(4'd2, v); chk(v == 32'd128, "R3 illegal size 513 ignored", v, 128);
    wr(4'd2, 32'd256);  rd(4'd2, v); chk(v == 32'd256, "R3 legal size 256", v, 256);

    for (int k = 0; k < 3; k++) begin
      wr(4'd2, 32'd128 << k);
      m_words = (128 << k) / 8;
      rdy_mode = k;
      wr(4'd0, 32'd1);
      if (k == 0) begin
        chk(tx_valid == 1'b0, "R2 no valid one edge after write", 64'(tx_valid), 0);
        @(negedge clk);
        chk(tx_valid == 1'b1 && tx_sop == 1'b1, "R2 SOP on second edge", {tx_valid, tx_sop}, 2'b11);
      end
      wait_done();
      rd(4'd0, v); chk(v == 32'd0, "R4 run bit auto-cleared", v, 0);
      rd(4'd4, v); chk(v == 100 * (k + 1), "R4 R8 sent SOP count", v, 100 * (k + 1));
      rd(4'd5, v); chk(v == 100 * (k + 1), "R8 sent EOP count", v, 100 * (k + 1));
      rd(4'd6, v); chk(v == 100 * (k + 1), "R9 received SOP count", v, 100 * (k + 1));
      rd(4'd7, v); chk(v == 100 * (k + 1), "R9 received EOP count", v, 100 * (k + 1));
      rd(4'd8, v); chk(v == 32'd0, "R10 no flags on clean loopback", v, 0);
      rd(4'd9, v); chk(v == 32'd0, "R10 no error count on clean loopback", v, 0);
      rd(4'd10, v); chk(v[0] == 1'b1, "R12 counts agree after batch", 64'(v[0]), 1);
      if (k == 0) begin
        wr(4'd3, 32'd2);
        rd(4'd10, v); chk(v[0] == 1'b0, "R12 counter-reset clears flag", 64'(v[0]), 0);
        repeat (10) @(negedge clk);
        rd(4'd10, v); chk(v[0] == 1'b0, "R12 flag stays clear without traffic", 64'(v[0]), 0);
      end
    end

    wr(4'd2, 32'd128); m_words = 16; rdy_mode = 1;
    wr(4'd1, 32'd1);
    wr(4'd0, 32'd1);
    forever begin
      rd(4'd4, v);
      if (v >= 32'd420) break;
    end
    rd(4'd0, v); chk(v == 32'd1, "R5 still running past 100 packets", v, 1);
    wr(4'd0, 32'd0);
    wait_done();
    rd(4'd4, a); rd(4'd5, b);
    chk(a == b, "R2 stop at packet boundary", a, b);
    chk(a >= 32'd420, "R5 endless run exceeded batch", a, 420);
    rd(4'd6, v); chk(v == a, "R9 received SOPs after stop", v, a);
    rd(4'd7, v); chk(v == b, "R9 received EOPs after stop", v, b);
    rd(4'd10, v); chk(v[0] == 1'b1, "R12 counts agree after stop", 64'(v[0]), 1);
    wr(4'd1, 32'd0);

    n = a;
    inj = 1'b1;
    send(n, -1, -1, 4);
    rd(4'd8, v); chk(v == 32'd0, "R10 clean injected packet", v, 0);
    send(n + 1, -1, 2, 4);
    rd(4'd8, v); chk(v == 32'd4, "R10 payload error bit 2", v, 4);
    rd(4'd9, v); chk(v == 32'd1, "R10 one bad beat counted", v, 1);
    wr(4'd3, 32'd1);
    rd(4'd8, v); chk(v == 32'd0, "R11 flags cleared", v, 0);
    rd(4'd9, v); chk(v == 32'd0, "R11 error count cleared", v, 0);
    rd(4'd2, v); chk(v == 32'd128, "R11 size kept", v, 128);
    rd(4'd1, v); chk(v == 32'd0, "R11 mode kept", v, 0);
    send(n + 2, 1, -1, 4);
    rd(4'd8, v); chk(v == 32'd2, "R10 channel error bit 1", v, 2);
    wr(4'd3, 32'd1);
    send(n + 7, -1, -1, 4);
    rd(4'd8, v); chk(v == 32'd1, "R10 order error bit 0", v, 1);
    rd(4'd9, v); chk(v == 32'd1, "R10 order error counted once", v, 1);
    wr(4'd3, 32'd1);
    send(n + 8, -1, -1, 4);
    rd(4'd8, v); chk(v == 32'd0, "R10 checker resynchronised", v, 0);
    @(negedge clk); i_valid = 1'b1; i_sop = 1'b0; i_eop = 1'b0; i_data = '0;
    @(negedge clk); i_valid = 1'b0;
    repeat (3) @(negedge clk);
    rd(4'd8, v); chk(v == 32'd8, "R10 framing error bit 3", v, 8);
    rd(4'd6, v); chk(v == a + 32'd5, "R9 injected SOPs counted", v, a + 5);
    rd(4'd7, v); chk(v == a + 32'd5, "R9 injected EOPs counted", v, a + 5);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule